// File: doc/BRIEF.md
# DMA Channel Ownership and Descriptor Registers

This block is the software-facing register file for a set of DMA channels. Each channel owns a 4 KB slice of the address window. The upper address bits select the channel and the low twelve bits select a register. Software first takes ownership of a channel by setting its claim bit. It then programs a pending descriptor (transfer configuration, byte count, destination address, source address) and sets run. When a run is accepted, the pending descriptor is frozen into a read-only set of in-flight copies, and a one-cycle start pulse goes to a separate transfer engine. The engine moves the data and reports back with a completion strobe and an error flag.

The bus is a single-cycle access port. Each access is either 4 or 8 bytes wide. A 4-byte access always carries its data in bits 31:0, both for writes and for read data. Reads are combinational from the address and size presented with `bus_valid` high and `bus_write` low. Writes take effect at the clock edge where `bus_valid` and `bus_write` are both high. Each channel drives two interrupt lines: one for finished transfers and one for failed transfers.

Top module: `dma_claim_regs`

## Requirements
- R1: After reset, every control word reads 0 and every next-configuration word reads 0x6600_0000 (read size 6 in bits 31:28, write size 6 in bits 27:24). All other registers read 0, and all start pulses and interrupt lines are low.
- R2: A control write that changes claim (control bit 0) from 0 to 1 clears next-bytes, next-destination and next-source, and reloads next-configuration with 0x6600_0000. A control write to an already claimed channel leaves those registers unchanged.
- R3: Next-bytes (0x008), next-destination (0x010) and next-source (0x018) accept 8-byte accesses at their base offset. They also accept 4-byte accesses, with the low half at the base offset and the high half at base+4. A 4-byte write replaces only its own half, using write data bits 31:0, and a 4-byte read returns the half in bits 31:0 with bits 63:32 zero.
- R4: If the channel was unclaimed before a control write, the stored run bit (control bit 1) is forced to 0 and no start pulse is issued.
- R5: A control write that sets run on a claimed, idle channel is accepted. In the cycle after that write, the channel's `eng_start` bit is high for exactly one cycle. The in-flight configuration (0x104), byte count (0x108), destination (0x110) and source (0x118) take the pending values, and done (bit 30) and error (bit 31) are cleared.
- R6: While run is set, a control write with claim 0 is stored with claim still 1.
- R7: An `eng_cpl` strobe while run is set clears run at that clock edge. It also sets done (bit 30) when `eng_cpl_err` is 0, or error (bit 31) when `eng_cpl_err` is 1.
- R8: `irq[2*ch]` is high exactly when done-enable (bit 14) and done are both set. `irq[2*ch+1]` is high exactly when error-enable (bit 15) and error are both set. A control write that clears a status bit or its enable lowers the line.
- R9: The in-flight registers ignore both 4-byte and 8-byte writes.
- R10: Accesses whose size is not 4 or 8, offsets with no register behind them (including 8-byte accesses to 0x000 and 0x004), and channel numbers at or above `NUM_CH` read 0 and change nothing.
- R11: A control write with claim 0 to a claimed channel whose run is low stores run as 0 and issues no start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 4 | Access width in bytes (4 or 8 are legal) |
| bus_addr | input | ADDR_W | Byte address; bits above 11 select the channel |
| bus_wdata | input | 64 | Write data; 4-byte accesses use bits 31:0 |
| bus_rdata | output | 64 | Read data, combinational |
| eng_start | output | NUM_CH | One-cycle start pulse per channel |
| eng_cpl | input | NUM_CH | Completion strobe per channel from the engine |
| eng_cpl_err | input | NUM_CH | Completion ended in error, qualified by eng_cpl |
| irq | output | 2*NUM_CH | Done line at 2*ch, error line at 2*ch+1 |

## Verification
The hardest situation to reach is a control write that arrives while a transfer is still outstanding. This is where the claim bit must survive an attempted release and a repeated run must not start a second transfer. The bench reaches it by accepting a run and then holding back the engine completion strobe. While the channel sits in the running state, the bench issues its control writes, and only afterwards releases completion, once with the error flag low and once with it high. The unclaimed and released-while-idle paths are exercised on a second channel, so that the first channel's state cannot hide a wrongly accepted run.

// File: rtl/pdma_regs_pkg.sv
// Shared definitions for the DMA channel register block.
// Assumes: 64-bit data path, 4 KB register slice per channel.
package pdma_regs_pkg;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CTRL, SEL_NCFG, SEL_NBYTES, SEL_NDST, SEL_NSRC,
        SEL_XCFG, SEL_XBYTES, SEL_XDST, SEL_XSRC
    } reg_sel_e;

    typedef enum logic [1:0] {
        PART_FULL, PART_LO, PART_HI
    } part_e;

    localparam int CTL_CLAIM   = 0;
    localparam int CTL_RUN     = 1;
    localparam int CTL_DONE_IE = 14;
    localparam int CTL_ERR_IE  = 15;
    localparam int CTL_DONE    = 30;
    localparam int CTL_ERR     = 31;

    localparam logic [31:0] CFG_DEFAULT = 32'h6600_0000;

endpackage

// File: rtl/pdma_decode.sv
// Address decoder: splits a bus address into a channel number and a
// register/half selection. Anything that is not a legal access yields SEL_NONE.
// Assumes: NUM_CH fits in the channel slot bits above bit 11.
module pdma_decode
    import pdma_regs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SLOT_W = ADDR_W - 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    output reg_sel_e          sel,
    output part_e             part,
    output logic [CH_W-1:0]   ch_idx,
    output logic              ch_ok
);

    logic [SLOT_W-1:0] slot;
    logic [11:0]       off;

    assign slot   = addr[ADDR_W-1:12];
    assign off    = addr[11:0];
    assign ch_idx = slot[CH_W-1:0];
    assign ch_ok  = {1'b0, slot} < (SLOT_W+1)'(NUM_CH);

    // Map offset and width to a register and half.
    always_comb begin
        sel  = SEL_NONE;
        part = PART_LO;
        if (size == 4'd4) begin
            case (off)
                12'h000: sel = SEL_CTRL;
                12'h004: sel = SEL_NCFG;
                12'h008: sel = SEL_NBYTES;
                12'h00C: begin sel = SEL_NBYTES; part = PART_HI; end
                12'h010: sel = SEL_NDST;
                12'h014: begin sel = SEL_NDST;   part = PART_HI; end
                12'h018: sel = SEL_NSRC;
                12'h01C: begin sel = SEL_NSRC;   part = PART_HI; end
                12'h104: sel = SEL_XCFG;
                12'h108: sel = SEL_XBYTES;
                12'h10C: begin sel = SEL_XBYTES; part = PART_HI; end
                12'h110: sel = SEL_XDST;
                12'h114: begin sel = SEL_XDST;   part = PART_HI; end
                12'h118: sel = SEL_XSRC;
                12'h11C: begin sel = SEL_XSRC;   part = PART_HI; end
                default: sel = SEL_NONE;
            endcase
        end else if (size == 4'd8) begin
            part = PART_FULL;
            case (off)
                12'h008: sel = SEL_NBYTES;
                12'h010: sel = SEL_NDST;
                12'h018: sel = SEL_NSRC;
                12'h108: sel = SEL_XBYTES;
                12'h110: sel = SEL_XDST;
                12'h118: sel = SEL_XSRC;
                default: sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/pdma_channel.sv
// One channel: control word with claim/run ownership rules, pending
// descriptor, in-flight copies, start pulse and interrupt lines.
// Assumes: wr_en is already qualified with channel match and legal decode.
module pdma_channel
    import pdma_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  part_e       part,
    input  logic [63:0] wdata,
    input  logic        cpl,
    input  logic        cpl_err,
    output logic [63:0] rdata,
    output logic        start,
    output logic        irq_done,
    output logic        irq_err
);

    logic [31:0] ctrl_q, ctrl_d, ctl_v, ncfg_q, xcfg_q;
    logic [63:0] nbytes_q, ndst_q, nsrc_q, xbytes_q, xdst_q, xsrc_q;
    logic        start_q, ctrl_wr, claimed, running, accept, claim_rise;

    function automatic logic [63:0] merge(input logic [63:0] old_v,
                                          input part_e p,
                                          input logic [63:0] nv);
        case (p)
            PART_FULL: merge = nv;
            PART_HI:   merge = {nv[31:0], old_v[31:0]};
            default:   merge = {old_v[63:32], nv[31:0]};
        endcase
    endfunction

    function automatic logic [63:0] pick(input logic [63:0] v, input part_e p);
        case (p)
            PART_FULL: pick = v;
            PART_HI:   pick = {32'd0, v[63:32]};
            default:   pick = {32'd0, v[31:0]};
        endcase
    endfunction

    assign ctrl_wr    = wr_en && (sel == SEL_CTRL);
    assign claimed    = ctrl_q[CTL_CLAIM];
    assign running    = ctrl_q[CTL_RUN];
    assign claim_rise = ctrl_wr && !claimed && wdata[CTL_CLAIM];

    // Apply ownership rules to the written control value and detect a start.
    always_comb begin
        ctl_v = wdata[31:0];
        if (running && !ctl_v[CTL_CLAIM]) ctl_v[CTL_CLAIM] = 1'b1;
        if (!claimed || (!running && !ctl_v[CTL_CLAIM])) ctl_v[CTL_RUN] = 1'b0;
        accept = ctrl_wr && ctl_v[CTL_RUN] && !running;
        if (accept) begin
            ctl_v[CTL_DONE] = 1'b0;
            ctl_v[CTL_ERR]  = 1'b0;
        end
    end

    // Next control word: software write, then engine completion on top.
    always_comb begin
        ctrl_d = ctrl_wr ? ctl_v : ctrl_q;
        if (cpl && running) begin
            ctrl_d[CTL_RUN] = 1'b0;
            if (cpl_err) ctrl_d[CTL_ERR]  = 1'b1;
            else         ctrl_d[CTL_DONE] = 1'b1;
        end
    end

    // Control register and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            start_q <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_d;
            start_q <= accept;
        end
    end

    // Pending descriptor: reset on fresh claim, else software writes.
    always_ff @(posedge clk) begin
        if (!rst_n || claim_rise) begin
            ncfg_q   <= CFG_DEFAULT;
            nbytes_q <= '0;
            ndst_q   <= '0;
            nsrc_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_NCFG:   ncfg_q   <= wdata[31:0];
                SEL_NBYTES: nbytes_q <= merge(nbytes_q, part, wdata);
                SEL_NDST:   ndst_q   <= merge(ndst_q, part, wdata);
                SEL_NSRC:   nsrc_q   <= merge(nsrc_q, part, wdata);
                default: ;
            endcase
        end
    end

    // In-flight copies: loaded only when a run is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xcfg_q   <= '0;
            xbytes_q <= '0;
            xdst_q   <= '0;
            xsrc_q   <= '0;
        end else if (accept) begin
            xcfg_q   <= ncfg_q;
            xbytes_q <= nbytes_q;
            xdst_q   <= ndst_q;
            xsrc_q   <= nsrc_q;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (sel)
            SEL_CTRL:   rdata = {32'd0, ctrl_q};
            SEL_NCFG:   rdata = {32'd0, ncfg_q};
            SEL_XCFG:   rdata = {32'd0, xcfg_q};
            SEL_NBYTES: rdata = pick(nbytes_q, part);
            SEL_NDST:   rdata = pick(ndst_q, part);
            SEL_NSRC:   rdata = pick(nsrc_q, part);
            SEL_XBYTES: rdata = pick(xbytes_q, part);
            SEL_XDST:   rdata = pick(xdst_q, part);
            SEL_XSRC:   rdata = pick(xsrc_q, part);
            default:    rdata = '0;
        endcase
    end

    assign start    = start_q;
    assign irq_done = ctrl_q[CTL_DONE_IE] && ctrl_q[CTL_DONE];
    assign irq_err  = ctrl_q[CTL_ERR_IE] && ctrl_q[CTL_ERR];

    assert_claim_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTL_RUN] |-> ctrl_q[CTL_CLAIM]);

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);

    assert_start_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (ctrl_q[CTL_RUN] && !ctrl_q[CTL_DONE] && !ctrl_q[CTL_ERR]));

    assert_unclaimed_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_q[CTL_CLAIM]) |=> !start_q);

    assert_cpl_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl && ctrl_q[CTL_RUN] && !cpl_err) |=> (!ctrl_q[CTL_RUN] && ctrl_q[CTL_DONE]));

    assert_cpl_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl && ctrl_q[CTL_RUN] && cpl_err) |=> (!ctrl_q[CTL_RUN] && ctrl_q[CTL_ERR]));

    assert_exec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(xbytes_q) && $stable(xdst_q) && $stable(xsrc_q) && $stable(xcfg_q)));

endmodule

// File: rtl/dma_claim_regs.sv
// Top: decodes the bus access, fans writes out to one register set per
// channel, selects read data and gathers start pulses and interrupt lines.
// Assumes: single-cycle accesses, 4-byte data in bits 31:0.
module dma_claim_regs
    import pdma_regs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [3:0]          bus_size,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [63:0]         bus_wdata,
    output logic [63:0]         bus_rdata,
    output logic [NUM_CH-1:0]   eng_start,
    input  logic [NUM_CH-1:0]   eng_cpl,
    input  logic [NUM_CH-1:0]   eng_cpl_err,
    output logic [2*NUM_CH-1:0] irq
);

    reg_sel_e        sel;
    part_e           part;
    logic [CH_W-1:0] ch_idx;
    logic            ch_ok;
    logic            wr_any;
    logic [63:0]     ch_rdata [NUM_CH];

    pdma_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
        .addr   (bus_addr),
        .size   (bus_size),
        .sel    (sel),
        .part   (part),
        .ch_idx (ch_idx),
        .ch_ok  (ch_ok)
    );

    assign wr_any = bus_valid && bus_write && ch_ok && (sel != SEL_NONE);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pdma_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_any && (ch_idx == CH_W'(i))),
            .sel      (sel),
            .part     (part),
            .wdata    (bus_wdata),
            .cpl      (eng_cpl[i]),
            .cpl_err  (eng_cpl_err[i]),
            .rdata    (ch_rdata[i]),
            .start    (eng_start[i]),
            .irq_done (irq[2*i]),
            .irq_err  (irq[2*i+1])
        );
    end

    // Read data: only for a legal read to an existing channel.
    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write && ch_ok) bus_rdata = ch_rdata[ch_idx];
    end

endmodule

// File: tb/tb_dma_claim_regs.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_dma_claim_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]        bus_size = 4'd4;
    logic [15:0]       bus_addr = '0;
    logic [63:0]       bus_wdata = '0;
    logic [63:0]       bus_rdata;
    logic [NUM_CH-1:0] eng_start;
    logic [NUM_CH-1:0] eng_cpl = '0, eng_cpl_err = '0;
    logic [2*NUM_CH-1:0] irq;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [63:0] SRC  = 64'h0000_0001_0000_8000;
    localparam logic [63:0] DST  = 64'h0000_0002_0000_4000;

    dma_claim_regs #(.ADDR_W(16), .NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .eng_start(eng_start), .eng_cpl(eng_cpl),
        .eng_cpl_err(eng_cpl_err), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sz, input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] sz, input logic [15:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_size = sz; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic complete(input int ch, input logic err);
        @(negedge clk);
        eng_cpl[ch] = 1'b1; eng_cpl_err[ch] = err;
        @(negedge clk);
        eng_cpl = '0; eng_cpl_err = '0;
    endtask

    task automatic t_reset;
        logic [63:0] d;
        rd(4, 16'h0000, d); check("R1 ctrl", d, 64'h0);
        rd(4, 16'h1004, d); check("R1 ncfg", d, 64'h6600_0000);
        rd(8, 16'h0008, d); check("R1 nbytes", d, 64'h0);
        rd(8, 16'h0118, d); check("R1 xsrc", d, 64'h0);
        check("R1 irq", {60'd0, irq}, 64'h0);
        check("R1 start", {62'd0, eng_start}, 64'h0);
    endtask

    task automatic t_claim;
        logic [63:0] d;
        wr(8, 16'h0008, 64'h1234);
        wr(4, 16'h0004, 64'h0000_000C);
        wr(8, 16'h0018, 64'h55);
        wr(4, 16'h0000, 64'h1);
        rd(8, 16'h0008, d); check("R2 nbytes cleared", d, 64'h0);
        rd(8, 16'h0018, d); check("R2 nsrc cleared", d, 64'h0);
        rd(4, 16'h0004, d); check("R2 ncfg default", d, 64'h6600_0000);
        wr(8, 16'h0008, 64'h5);
        wr(4, 16'h0000, 64'h1);
        rd(8, 16'h0008, d); check("R2 reclaim keeps nbytes", d, 64'h5);
    endtask

    task automatic t_halves;
        logic [63:0] d;
        wr(8, 16'h0010, 64'h1111_2222_3333_4444);
        wr(4, 16'h0014, 64'h0000_0000_AAAA_BBBB);
        rd(8, 16'h0010, d); check("R3 high half write", d, 64'hAAAA_BBBB_3333_4444);
        rd(4, 16'h0010, d); check("R3 low half read", d, 64'h3333_4444);
        rd(4, 16'h0014, d); check("R3 high half read", d, 64'hAAAA_BBBB);
        wr(4, 16'h0010, 64'hFFFF_FFFF_0000_0055);
        rd(8, 16'h0010, d); check("R3 low half write", d, 64'hAAAA_BBBB_0000_0055);
    endtask

    task automatic t_unclaimed;
        logic [63:0] d;
        wr(4, 16'h1000, 64'h2);
        check("R4 no start (run only)", {62'd0, eng_start}, 64'h0);
        rd(4, 16'h1000, d); check("R4 run dropped", d, 64'h0);
        wr(4, 16'h1000, 64'h3);
        check("R4 no start (claim+run)", {62'd0, eng_start}, 64'h0);
        rd(4, 16'h1000, d); check("R4 claim kept, run dropped", d, 64'h1);
    endtask

    task automatic t_disclaim;
        logic [63:0] d;
        wr(4, 16'h1000, 64'h2);
        check("R11 no start", {62'd0, eng_start}, 64'h0);
        rd(4, 16'h1000, d); check("R11 run dropped", d, 64'h0);
    endtask

    task automatic t_run;
        logic [63:0] d;
        wr(8, 16'h0008, 64'h100);
        wr(8, 16'h0010, DST);
        wr(8, 16'h0018, SRC);
        wr(4, 16'h0004, 64'h3300_0000);
        wr(4, 16'h0000, 64'hC000_C003);
        check("R5 start high", {62'd0, eng_start}, 64'h1);
        @(negedge clk);
        check("R5 start one cycle", {62'd0, eng_start}, 64'h0);
        rd(4, 16'h0000, d); check("R5 status cleared", d, 64'h0000_C003);
        rd(8, 16'h0108, d); check("R5 xbytes", d, 64'h100);
        rd(8, 16'h0110, d); check("R5 xdst", d, DST);
        rd(8, 16'h0118, d); check("R5 xsrc", d, SRC);
        rd(4, 16'h0104, d); check("R5 xcfg", d, 64'h3300_0000);
        wr(4, 16'h0000, 64'h0000_C002);
        check("R6 no second start", {62'd0, eng_start}, 64'h0);
        rd(4, 16'h0000, d); check("R6 claim held", d, 64'h0000_C003);
    endtask

    task automatic t_complete;
        logic [63:0] d;
        complete(0, 1'b0);
        rd(4, 16'h0000, d); check("R7 done set, run clear", d, 64'h4000_C001);
        check("R8 done irq", {60'd0, irq}, 64'h1);
        wr(4, 16'h0000, 64'h0000_C001);
        check("R8 done cleared by write", {60'd0, irq}, 64'h0);
        wr(4, 16'h0000, 64'h0000_C003);
        complete(0, 1'b1);
        rd(4, 16'h0000, d); check("R7 error set, run clear", d, 64'h8000_C001);
        check("R8 error irq", {60'd0, irq}, 64'h2);
        wr(4, 16'h0000, 64'h8000_0001);
        check("R8 enable gates error irq", {60'd0, irq}, 64'h0);
    endtask

    task automatic t_readonly;
        logic [63:0] d;
        wr(4, 16'h0108, 64'hDEAD);
        wr(8, 16'h0110, 64'h77);
        wr(4, 16'h0104, 64'h1);
        wr(4, 16'h011C, 64'hFFFF);
        rd(8, 16'h0108, d); check("R9 xbytes held", d, 64'h100);
        rd(8, 16'h0110, d); check("R9 xdst held", d, DST);
        rd(4, 16'h0104, d); check("R9 xcfg held", d, 64'h3300_0000);
        rd(8, 16'h0118, d); check("R9 xsrc held", d, SRC);
    endtask

    task automatic t_illegal;
        logic [63:0] d;
        wr(2, 16'h0004, 64'h0);
        wr(8, 16'h0004, 64'h0);
        rd(4, 16'h0004, d); check("R10 bad writes ignored", d, 64'h3300_0000);
        rd(2, 16'h0004, d); check("R10 bad size reads 0", d, 64'h0);
        rd(8, 16'h0000, d); check("R10 wide ctrl reads 0", d, 64'h0);
        rd(4, 16'h0020, d); check("R10 unmapped reads 0", d, 64'h0);
        wr(4, 16'h3000, 64'h1);
        rd(4, 16'h3000, d); check("R10 missing channel reads 0", d, 64'h0);
        rd(4, 16'h1000, d); check("R10 ch1 untouched", d, 64'h0);
        rd(4, 16'h0000, d); check("R10 ch0 untouched", d, 64'h8000_0001);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_claim;
        t_halves;
        t_unclaimed;
        t_disclaim;
        t_run;
        t_complete;
        t_readonly;
        t_illegal;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule